// File: doc/BRIEF.md
# Serial Peripheral Master with Framed Block Transfers

This block is a synchronous serial master that moves words of 1 to 16 bits from a transmit queue onto a data-out pin and collects the matching data-in bits into a receive queue. The serial clock idle level, the edge used for sampling, the bit-clock rate and the word length are all set by configuration inputs. These inputs are sampled live and must be held stable while a transfer is in flight. One of eight active-low select lines, picked by a 3-bit index, frames each transfer.

There are two framing modes. In streaming mode, the select line stays low for as long as the transmit queue keeps supplying words. In block mode, each transmit entry carries two framing flags. A stop flag closes the frame after that word is shifted. Stop and skip together close the frame without shifting anything. Each received word is tagged when it is the first word of its frame. A loopback switch feeds the serial output straight back into the receive path, which allows a self-test with no external device.

Software-visible registers are outside this block. Configuration arrives on plain inputs. Data enters through a valid/ready push port and leaves through a valid/ready pop port.

Top module: `spim_master`

## Requirements
- R1: A word is `cfg_ws + 1` bits long and is shifted most significant bit first. Transmit bits above that length are never sent. The received word sits in the low bits of `rx_data`, with the upper bits zero.
- R2: While `busy` is low, `sclk` equals `cfg_cpol`. With `cfg_cpha` = 0, the data-in pin is sampled on the leading (first) edge of each bit and `mosi` changes on the trailing edge. With `cfg_cpha` = 1, `mosi` changes on the leading edge and the data-in pin is sampled on the trailing edge.
- R3: The serial clock half period is H = E × (`cfg_rate` + 1) system clocks. E is `cfg_presc` with bit 0 cleared, and a result of 0 is replaced by 1. The first serial clock edge comes H cycles after the select line goes low, and successive edges are H cycles apart.
- R4: During a frame, only `cs_n[cfg_csidx]` is low. All eight lines are high when no frame is active.
- R5: With `cfg_blk` = 0, words pushed back to back form one frame, and their flags are ignored. The frame closes once the queue is empty and the last word has finished.
- R6: With `cfg_blk` = 1, the frame closes after a word pushed with `tx_stop` = 1. The next word opens a new frame.
- R7: With `cfg_blk` = 1, if the queue runs empty before a stop word, the select line stays low and `busy` stays high until more data arrives.
- R8: With `cfg_blk` = 1, an entry with both `tx_stop` and `tx_skip` set closes the current frame without shifting any bits. If no frame is open, the entry is consumed and nothing happens. `tx_skip` without `tx_stop` has no effect.
- R9: `rx_first` is 1 for the first word received in each frame when `cfg_blk` = 1, and 0 for every other word. It is always 0 when `cfg_blk` = 0.
- R10: With `cfg_loop` = 1, each received word equals the transmitted word, whatever is on `miso`.
- R11: A frame starts only while `cfg_enable` = 1. Until then, pushed words wait in the queue.
- R12: `busy` is high from the cycle the select line goes low until the cycle it returns high.
- R13: `tx_ready` is low while the transmit queue holds TX_DEPTH entries, and a push in that state is dropped. `rx_valid` is high while received words are queued, and `rx_data`/`rx_first` show the oldest one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Allows new frames to start |
| cfg_blk | input | 1 | Block framing mode |
| cfg_loop | input | 1 | Internal loopback of mosi to the receive path |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Sample on trailing edge when 1 |
| cfg_ws | input | 4 | Word length minus one |
| cfg_presc | input | 8 | Clock prescaler, bit 0 ignored |
| cfg_rate | input | 8 | Clock rate multiplier minus one |
| cfg_csidx | input | 3 | Select line index |
| tx_valid | input | 1 | Transmit push request |
| tx_ready | output | 1 | Transmit queue has room |
| tx_data | input | 16 | Transmit word |
| tx_stop | input | 1 | Close frame after this word (block mode) |
| tx_skip | input | 1 | With stop: close frame with no data |
| rx_valid | output | 1 | Receive queue not empty |
| rx_ready | input | 1 | Pop the oldest received word |
| rx_data | output | 16 | Oldest received word |
| rx_first | output | 1 | Oldest word was first in its frame |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 8 | Active-low select lines |
| busy | output | 1 | Frame in progress |

## Verification
Two events can land in the same cycle: the receive store of a completed word and the fetch of the next transmit entry, which may be a stop-and-skip entry that closes the frame. The bench provokes this by queuing a data word followed directly by a stop-and-skip entry, and then a word with only the skip flag, before enabling the block. The two functions are judged independently. The frame count and select-line activity show whether the frame ended at the right point, and the popped receive words, with their first-word tags, show that the store in the same cycle was not lost.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;
  localparam int DATA_W = 16;
  localparam int WS_W   = $clog2(DATA_W);
  localparam int CS_N   = 8;
  localparam int CSI_W  = $clog2(CS_N);
  localparam int PRE_W  = 8;
  localparam int HP_W   = 2 * PRE_W;
  localparam int EC_W   = $clog2(2 * DATA_W) + 1;

  typedef struct packed {
    logic              stop;
    logic              skip;
    logic [DATA_W-1:0] data;
  } tx_ent_t;

  typedef struct packed {
    logic              first;
    logic [DATA_W-1:0] data;
  } rx_ent_t;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_HOLD, S_TAIL} eng_state_t;

  // half period of the serial clock in system clocks
  function automatic logic [HP_W-1:0] half_period(input logic [PRE_W-1:0] presc,
                                                  input logic [PRE_W-1:0] rate);
    logic [PRE_W-1:0] eff;
    eff = {presc[PRE_W-1:1], 1'b0};
    if (eff == '0) eff = PRE_W'(1);
    return HP_W'(eff) * (HP_W'(rate) + HP_W'(1));
  endfunction

  // low (ws+1) bits set
  function automatic logic [DATA_W-1:0] word_mask(input logic [WS_W-1:0] ws);
    logic [DATA_W:0] m;
    m = ((DATA_W+1)'(1) << ({1'b0, ws} + (WS_W+1)'(1))) - (DATA_W+1)'(1);
    return m[DATA_W-1:0];
  endfunction
endpackage

// File: rtl/spim_fifo.sv
`timescale 1ns/1ps
module spim_fifo #(
  parameter int W     = 18,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] din,
  input  logic         pop_i,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push_i && !full;
  assign do_pop  = pop_i && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + AW'(1);
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + AW'(1);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  // a full queue with no pop stays full: extra pushes are dropped
  p_full_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop_i) |=> full);
  p_empty_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push_i) |=> empty);
endmodule

// File: rtl/spim_tick.sv
`timescale 1ns/1ps
module spim_tick #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [CW-1:0] half,
  output logic          tick
);
  logic [CW-1:0] cnt;

  assign tick = !clr && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (clr || cnt == '0)   cnt <= half - CW'(1);
    else                         cnt <= cnt - CW'(1);
  end
endmodule

// File: rtl/spim_engine.sv
`timescale 1ns/1ps
module spim_engine
  import spim_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_enable,
  input  logic            cfg_blk,
  input  logic            cfg_cpha,
  input  logic [WS_W-1:0] cfg_ws,
  input  logic            tick,
  output logic            tick_clr,
  input  tx_ent_t         tx_head,
  input  logic            tx_avail,
  output logic            tx_pop,
  output logic            word_end,
  output rx_ent_t         rx_ent,
  input  logic            miso_in,
  output logic            mosi,
  output logic            phase,
  output logic            active
);
  eng_state_t        state, nxt;
  logic [DATA_W-1:0] tx_sr, rx_sr, rx_next;
  logic [EC_W-1:0]   edge_cnt, e_num, two_n;
  logic              cur_stop, first_pend;
  logic              shifting, lead, samp_ev, shift_ev;
  logic              end_entry, load, frame_start;

  assign two_n     = EC_W'({1'b0, cfg_ws} + (WS_W+1)'(1)) << 1;
  assign e_num     = edge_cnt + EC_W'(1);
  assign lead      = e_num[0];
  assign shifting  = tick && (state == S_SHIFT);
  assign samp_ev   = shifting && (cfg_cpha ? !lead : lead);
  assign shift_ev  = shifting && (cfg_cpha ? (lead && e_num != EC_W'(1))
                                           : (!lead && e_num != two_n));
  assign word_end  = shifting && (e_num == two_n);
  assign end_entry = cfg_blk && tx_head.stop && tx_head.skip;
  assign rx_next   = {rx_sr[DATA_W-2:0], miso_in};
  assign rx_ent.data  = (cfg_cpha ? rx_next : rx_sr) & word_mask(cfg_ws);
  assign rx_ent.first = cfg_blk && first_pend;
  assign mosi      = tx_sr[cfg_ws];
  assign active    = (state != S_IDLE);
  assign tick_clr  = (state == S_IDLE) || (state == S_HOLD);

  always_comb begin
    nxt = state; tx_pop = 1'b0; load = 1'b0; frame_start = 1'b0;
    case (state)
      S_IDLE: if (cfg_enable && tx_avail) begin
        tx_pop = 1'b1;
        if (!end_entry) begin load = 1'b1; frame_start = 1'b1; nxt = S_SHIFT; end
      end
      S_SHIFT: if (word_end) begin
        if (cur_stop) nxt = S_TAIL;
        else if (tx_avail) begin
          tx_pop = 1'b1;
          if (end_entry) nxt = S_TAIL;
          else load = 1'b1;
        end else nxt = cfg_blk ? S_HOLD : S_TAIL;
      end
      S_HOLD: if (tx_avail) begin
        tx_pop = 1'b1;
        if (end_entry) nxt = S_TAIL;
        else begin load = 1'b1; nxt = S_SHIFT; end
      end
      S_TAIL: if (tick) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; tx_sr <= '0; rx_sr <= '0; edge_cnt <= '0;
      phase <= 1'b0; cur_stop <= 1'b0; first_pend <= 1'b0;
    end else begin
      state <= nxt;
      if (load) begin
        tx_sr    <= tx_head.data;
        cur_stop <= cfg_blk && tx_head.stop;
      end else if (shift_ev) tx_sr <= tx_sr << 1;
      if (load || word_end) edge_cnt <= '0;
      else if (shifting)    edge_cnt <= e_num;
      if (shifting) phase <= ~phase;
      if (samp_ev)  rx_sr <= rx_next;
      if (frame_start)   first_pend <= 1'b1;
      else if (word_end) first_pend <= 1'b0;
    end
  end

  // edge counter never passes the last edge of a word
  p_edge_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SHIFT) |-> (edge_cnt < two_n));
  // the final edge of every word returns the clock to its idle level
  p_word_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    word_end |=> !phase);
endmodule

// File: rtl/spim_master.sv
`timescale 1ns/1ps
module spim_master
  import spim_pkg::*;
#(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              cfg_blk,
  input  logic              cfg_loop,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic [WS_W-1:0]   cfg_ws,
  input  logic [PRE_W-1:0]  cfg_presc,
  input  logic [PRE_W-1:0]  cfg_rate,
  input  logic [CSI_W-1:0]  cfg_csidx,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_stop,
  input  logic              tx_skip,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_first,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [CS_N-1:0]   cs_n,
  output logic              busy
);
  tx_ent_t tx_in, tx_head;
  rx_ent_t rx_ent, rx_out;
  logic tx_full, tx_empty, rx_full, rx_empty, tx_pop;
  logic word_end, rx_push, tick, tick_clr, phase, miso_in;

  assign tx_in    = '{stop: tx_stop, skip: tx_skip, data: tx_data};
  assign tx_ready = !tx_full;
  assign rx_valid = !rx_empty;
  assign rx_data  = rx_out.data;
  assign rx_first = rx_out.first;
  assign rx_push  = word_end && !rx_full;
  assign miso_in  = cfg_loop ? mosi : miso;
  assign sclk     = cfg_cpol ^ phase;
  assign cs_n     = busy ? ~(CS_N'(1) << cfg_csidx) : '1;

  spim_fifo #(.W($bits(tx_ent_t)), .DEPTH(TX_DEPTH)) u_txq (
    .clk, .rst_n, .push_i(tx_valid), .din(tx_in), .pop_i(tx_pop),
    .dout(tx_head), .full(tx_full), .empty(tx_empty));

  spim_fifo #(.W($bits(rx_ent_t)), .DEPTH(RX_DEPTH)) u_rxq (
    .clk, .rst_n, .push_i(rx_push), .din(rx_ent), .pop_i(rx_ready),
    .dout(rx_out), .full(rx_full), .empty(rx_empty));

  spim_tick #(.CW(HP_W)) u_tick (
    .clk, .rst_n, .clr(tick_clr), .half(half_period(cfg_presc, cfg_rate)), .tick);

  spim_engine u_eng (
    .clk, .rst_n, .cfg_enable, .cfg_blk, .cfg_cpha, .cfg_ws,
    .tick, .tick_clr, .tx_head, .tx_avail(!tx_empty), .tx_pop,
    .word_end, .rx_ent, .miso_in, .mosi, .phase, .active(busy));

  p_cs_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  p_busy_cs_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cs_n[cfg_csidx]);
  p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == cfg_cpol));
endmodule

// File: tb/spim_master_test.sv
`timescale 1ns/1ps
module spim_master_test;
  logic clk = 0, rst_n = 0;
  logic cfg_enable = 0, cfg_blk = 0, cfg_loop = 0, cfg_cpol = 0, cfg_cpha = 0;
  logic [3:0] cfg_ws = 4'd7;
  logic [7:0] cfg_presc = 8'd2, cfg_rate = 8'd0;
  logic [2:0] cfg_csidx = 3'd0;
  logic tx_valid = 0, tx_stop = 0, tx_skip = 0, rx_ready = 0;
  logic [15:0] tx_data = 0;
  logic tx_ready, rx_valid, rx_first, sclk, mosi, busy;
  logic miso_r = 0;
  logic [15:0] rx_data;
  logic [7:0] cs_n;

  spim_master uut (
    .clk, .rst_n, .cfg_enable, .cfg_blk, .cfg_loop, .cfg_cpol, .cfg_cpha,
    .cfg_ws, .cfg_presc, .cfg_rate, .cfg_csidx, .tx_valid, .tx_ready,
    .tx_data, .tx_stop, .tx_skip, .rx_valid, .rx_ready, .rx_data, .rx_first,
    .sclk, .mosi, .miso(miso_r), .cs_n, .busy);

  always #4 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(negedge clk) if (cyc == 150000) begin
    failures++;
    $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
    finish_run();
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- serial slave model ----------------
  logic [15:0] s_pat = 0, s_cap = 0;
  int s_words [0:15];
  int s_nw = 0, s_cnt = 0, frames = 0, cs_bad = 0, cs_seen = 0;
  int c0 = 0, e1 = 0, e2 = 0, e_cnt = 0;
  logic mon_clr = 0, prev_act = 0, prev_sclk = 0, prev_mosi = 0;

  always @(negedge clk) begin
    logic act, lead;
    int n;
    n = int'(cfg_ws) + 1;
    act = (cs_n != 8'hFF);
    if (mon_clr) begin
      s_nw = 0; frames = 0; cs_bad = 0; e_cnt = 0;
    end else begin
      if (act && !prev_act) begin
        frames++; s_cnt = 0; e_cnt = 0; c0 = cyc;
        for (int k = 0; k < 8; k++) if (!cs_n[k]) cs_seen = k;
        miso_r = s_pat[n-1];
      end
      if (act && cs_n != ~(8'h01 << cfg_csidx)) cs_bad++;
      if (act && prev_act && sclk != prev_sclk) begin
        e_cnt++;
        if (e_cnt == 1) e1 = cyc;
        if (e_cnt == 2) e2 = cyc;
        lead = (sclk != cfg_cpol);
        if (lead ^ cfg_cpha) begin
          s_cap = {s_cap[14:0], prev_mosi};
          s_cnt++;
          if (s_cnt % n == 0) begin
            if (s_nw < 16) s_words[s_nw] = int'(s_cap) & ((1 << n) - 1);
            s_nw++;
          end
        end else miso_r = s_pat[n - 1 - (s_cnt % n)];
      end
    end
    prev_act = act; prev_sclk = sclk; prev_mosi = mosi;
  end

  // ---------------- helper tasks ----------------
  task automatic clr_mon();
    @(posedge clk); mon_clr = 1;
    @(posedge clk); mon_clr = 0;
  endtask

  task automatic push(input logic [15:0] d, input logic stp, input logic skp);
    @(negedge clk);
    tx_valid = 1; tx_data = d; tx_stop = stp; tx_skip = skp;
    @(negedge clk);
    tx_valid = 0; tx_stop = 0; tx_skip = 0;
  endtask

  task automatic pop_rx(output logic v, output int d, output logic f);
    @(negedge clk);
    v = rx_valid; d = int'(rx_data); f = rx_first;
    if (v) rx_ready = 1;
    @(negedge clk);
    rx_ready = 0;
  endtask

  task automatic wait_idle();
    int quiet;
    quiet = 0;
    while (quiet < 4) begin
      @(negedge clk);
      quiet = busy ? 0 : quiet + 1;
    end
  endtask

  task automatic expect_rx(input string req, input int d_exp, input logic f_exp);
    logic v, f; int d;
    pop_rx(v, d, f);
    chk(req, "rx_valid", int'(v), 1);
    chk(req, "rx_data", d, d_exp);
    chk("R9", "rx_first", int'(f), int'(f_exp));
  endtask

  // ws, cpol, cpha, presc, rate, csidx, tx word, slave pattern
  localparam logic [56:0] VEC [6] = '{
    {4'd7,  1'b0, 1'b0, 8'd2, 8'd0, 3'd0, 16'h00A5, 16'h003C},
    {4'd15, 1'b1, 1'b1, 8'd4, 8'd1, 3'd7, 16'hBEEF, 16'h1234},
    {4'd3,  1'b0, 1'b1, 8'd0, 8'd2, 3'd3, 16'h00F9, 16'hFFF6},
    {4'd0,  1'b1, 1'b0, 8'd1, 8'd0, 3'd5, 16'h0001, 16'h0001},
    {4'd11, 1'b0, 1'b0, 8'd7, 8'd0, 3'd2, 16'hFABC, 16'h05A5},
    {4'd7,  1'b1, 1'b1, 8'd3, 8'd3, 3'd6, 16'h123C, 16'h00C3}
  };

  initial begin
    logic v, f; int d;
    repeat (4) @(negedge clk);
    // reset state
    chk("R4", "cs_n at reset", int'(cs_n), 8'hFF);
    chk("R12", "busy at reset", int'(busy), 0);
    chk("R2", "sclk at reset", int'(sclk), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R13", "tx_ready after reset", int'(tx_ready), 1);
    chk("R13", "rx_valid after reset", int'(rx_valid), 0);

    // ---- table of single-word transfers ----
    cfg_enable = 1;
    for (int i = 0; i < 6; i++) begin
      logic [56:0] vv;
      int m, eff, h;
      vv = VEC[i];
      cfg_ws = vv[56:53]; cfg_cpol = vv[52]; cfg_cpha = vv[51];
      cfg_presc = vv[50:43]; cfg_rate = vv[42:35]; cfg_csidx = vv[34:32];
      s_pat = vv[15:0];
      m = (1 << (int'(vv[56:53]) + 1)) - 1;
      eff = (vv[50:43] < 2) ? 1 : int'(vv[50:43]) - int'(vv[50:43]) % 2;
      h = eff * (int'(vv[42:35]) + 1);
      @(negedge clk);
      chk("R2", "idle sclk level", int'(sclk), int'(vv[52]));
      clr_mon();
      push(vv[31:16], 0, 0);
      wait_idle();
      chk("R5", "frame count", frames, 1);
      chk("R1", "word count", s_nw, 1);
      chk("R1", "mosi word", s_words[0], int'(vv[31:16]) & m);
      chk("R4", "cs line", cs_seen, int'(vv[34:32]));
      chk("R4", "other cs lines", cs_bad, 0);
      chk("R3", "cs to first edge", e1 - c0, h);
      chk("R3", "edge spacing", e2 - e1, h);
      expect_rx("R2", int'(vv[15:0]) & m, 0);
    end

    // ---- R13 / R11: fill while disabled ----
    cfg_enable = 0; cfg_blk = 0; cfg_ws = 4'd7; cfg_cpol = 0; cfg_cpha = 0;
    cfg_presc = 8'd2; cfg_rate = 8'd0; cfg_csidx = 3'd1; s_pat = 16'h0081;
    clr_mon();
    for (int i = 0; i < 8; i++) push(16'h10 + 16'(i), 0, 0);
    chk("R13", "tx_ready when full", int'(tx_ready), 0);
    push(16'hEE, 0, 0);
    repeat (30) @(negedge clk);
    chk("R11", "no frame while disabled", frames, 0);
    chk("R11", "busy while disabled", int'(busy), 0);
    cfg_enable = 1;
    wait_idle();
    chk("R5", "one frame for 8 words", frames, 1);
    chk("R13", "dropped 9th push", s_nw, 8);
    for (int i = 0; i < 8; i++) begin
      chk("R13", "queue order", s_words[i], 16 + i);
      expect_rx("R13", 8'h81, 0);
    end
    @(negedge clk);
    chk("R13", "rx empty after drain", int'(rx_valid), 0);

    // ---- R5: streaming mode ignores flags ----
    cfg_enable = 0;
    clr_mon();
    push(16'h21, 0, 0); push(16'h22, 1, 1); push(16'h23, 1, 0);
    cfg_enable = 1;
    wait_idle();
    chk("R5", "flags ignored, one frame", frames, 1);
    chk("R5", "three words", s_nw, 3);
    for (int i = 0; i < 3; i++) expect_rx("R5", 8'h81, 0);

    // ---- R6 / R9: stop flag splits frames ----
    cfg_enable = 0; cfg_blk = 1;
    clr_mon();
    push(16'hA1, 0, 0); push(16'hA2, 1, 0); push(16'hA3, 0, 0); push(16'hA4, 1, 0);
    cfg_enable = 1;
    wait_idle();
    chk("R6", "two frames", frames, 2);
    chk("R6", "four words", s_nw, 4);
    chk("R6", "last word", s_words[3], 16'hA4);
    expect_rx("R6", 8'h81, 1); expect_rx("R6", 8'h81, 0);
    expect_rx("R6", 8'h81, 1); expect_rx("R6", 8'h81, 0);

    // ---- R8: stop+skip in idle, at a word boundary, skip alone ----
    cfg_enable = 0;
    clr_mon();
    push(16'hFF, 1, 1); push(16'hB1, 0, 0); push(16'hFF, 1, 1);
    push(16'hC1, 0, 1); push(16'hC2, 1, 0);
    cfg_enable = 1;
    wait_idle();
    chk("R8", "frames with stop+skip", frames, 2);
    chk("R8", "words shifted", s_nw, 3);
    chk("R8", "first frame word", s_words[0], 16'hB1);
    chk("R8", "skip alone ignored", s_words[1], 16'hC1);
    expect_rx("R8", 8'h81, 1); expect_rx("R8", 8'h81, 1); expect_rx("R8", 8'h81, 0);
    @(negedge clk);
    chk("R8", "no extra rx", int'(rx_valid), 0);

    // ---- R7: hold select when queue empties mid-frame ----
    clr_mon();
    push(16'hD1, 0, 0);
    repeat (100) @(negedge clk);
    chk("R7", "busy held", int'(busy), 1);
    chk("R7", "cs held low", int'(cs_n[1]), 0);
    chk("R7", "one word so far", s_nw, 1);
    chk("R7", "sclk idle in hold", int'(sclk), 0);
    push(16'hD2, 1, 0);
    wait_idle();
    chk("R7", "single frame", frames, 1);
    chk("R7", "second word", s_words[1], 16'hD2);
    expect_rx("R7", 8'h81, 1); expect_rx("R7", 8'h81, 0);

    // ---- R10: loopback ----
    cfg_blk = 0; cfg_loop = 1; cfg_ws = 4'd15; s_pat = 16'h0F0F;
    clr_mon();
    push(16'h5AC3, 0, 0);
    wait_idle();
    expect_rx("R10", 16'h5AC3, 0);
    cfg_loop = 0;

    finish_run();
  end
endmodule